// File: doc/BRIEF.md
# ADC Register Access SPI Sequencer

This block drives the configuration side of a multichannel delta-sigma converter over SPI. A host presents one request at a time: a standalone command byte, a single-register read or a single-register write. The block checks that the request is legal, builds the one-byte or three-byte frame, shifts it out in SPI mode 1 (clock idle low, data launched on the rising edge and sampled on the falling edge, MSB first), and then keeps chip select low for a fixed settling time before it releases it.

Command decode inside the converter takes several converter clocks, so the serial clock is divided down from the system clock. The divider is a parameter, and an elaboration check rejects any setting that would run it above the converter clock. The chip-select hold time is computed at elaboration from the system clock, the converter clock and the number of converter clocks required. Register caching, the streaming sample path and any meaning of register contents are left to other logic.

Top module: `adc_spi_seq`

## Requirements
- R1: While reset is asserted and after it is released, cs_n is 1, sclk is 0, mosi is 0, busy and done are 0 and rd_data is 0x00.
- R2: A request with req_op = 2'b00 whose req_wdata is one of 0x02, 0x04, 0x06, 0x08, 0x0A, 0x10, 0x11 or 0x12 produces a single 8-bit frame carrying that byte, MSB first.
- R3: A request with req_op = 2'b00 and any other byte, or with req_op = 2'b11, is ignored: cs_n stays 1 and busy stays 0.
- R4: A request with req_op = 2'b01 produces the 24-bit frame {0x20 OR address[4:0], 0x00, 0x00}. The 8 MISO bits sampled during the third byte, first bit as MSB, appear on rd_data in the cycle done is high.
- R5: A request with req_op = 2'b10 produces the 24-bit frame {0x40 OR address[4:0], 0x00, req_wdata}, and rd_data keeps its previous value.
- R6: A read or write request whose address is above 0x19 is ignored, with no chip-select activity.
- R7: sclk toggles only while cs_n is low. Each half period lasts HALF_DIV system cycles, and the first rising edge comes HALF_DIV cycles after cs_n falls. mosi changes only on a rising sclk edge or when cs_n is released.
- R8: After the last falling sclk edge of a frame, cs_n stays low for exactly ceil(CS_HOLD_CONV_CLKS x SYS_CLK_HZ / CONV_CLK_HZ) system cycles (245 with the defaults) and then rises.
- R9: busy is high from the cycle after a request is accepted until cs_n rises. done is a single-cycle pulse in the cycle cs_n rises.
- R10: A request presented while busy is high is ignored and has no effect on the frame in flight.
- R11: A legal request presented in the cycle done is high is accepted at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when busy is low |
| req_op | input | 2 | 00 command, 01 register read, 10 register write, 11 reserved |
| req_addr | input | ADDR_W | Register address for reads and writes |
| req_wdata | input | 8 | Command byte or write data |
| busy | output | 1 | A frame or its chip-select hold is in progress |
| done | output | 1 | One-cycle pulse when chip select is released |
| rd_data | output | 8 | Byte returned by the last register read |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench targets the edges of legality. These are the eight command codes next to near-miss bytes, register 0x19 next to 0x1A, and the reserved opcode. A design that decoded legality loosely would drop chip select for a byte that must be ignored. It times the first rising clock edge after chip select falls and the gap between the last falling edge and chip-select release, where an off-by-one in the divider or hold counter shows up as a half period or hold one cycle long or short. It also sends a request in the middle of a frame, which a design that did not gate on busy would let corrupt the shift register. It sends another request in the done cycle, which a design with an extra idle state would accept one cycle late. Read bytes of 0x81, 0xFF and 0x00 would expose a design that samples MISO on the wrong edge or a bit late.

// File: rtl/adc_spi_seq_pkg.sv
package adc_spi_seq_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned FRAME_W  = 24;
   localparam int unsigned N_CMDS   = 8;

   typedef enum logic [1:0] {
      OPC_CMD  = 2'b00,
      OPC_RD   = 2'b01,
      OPC_WR   = 2'b10,
      OPC_RSVD = 2'b11
   } req_op_e;

   localparam logic [BYTE_W-1:0] RD_BASE = 8'h20;
   localparam logic [BYTE_W-1:0] WR_BASE = 8'h40;

   // accepted standalone command codes, one byte per slot
   localparam logic [N_CMDS*BYTE_W-1:0] CMD_SET =
      {8'h12, 8'h11, 8'h10, 8'h0A, 8'h08, 8'h06, 8'h04, 8'h02};

   typedef struct packed {
      logic [FRAME_W-1:0] bits;       // left aligned, MSB goes first
      logic               long_frame; // 1: 24 bits, 0: 8 bits
      logic               is_read;
   } frame_t;

endpackage

// File: rtl/adc_spi_frame_build.sv
module adc_spi_frame_build
   import adc_spi_seq_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int REG_FIELD_W = 5,
   parameter int MAX_REG     = 25
) (
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              legal,
   output frame_t            frame
);

   localparam int PAD_W = BYTE_W - REG_FIELD_W;

   logic [N_CMDS-1:0] code_hit;
   logic              addr_ok;
   logic [BYTE_W-1:0] reg_field;

   for (genvar i = 0; i < N_CMDS; i++) begin : g_code
      assign code_hit[i] = (wdata == CMD_SET[i*BYTE_W +: BYTE_W]);
   end

   assign addr_ok   = (int'(addr) <= MAX_REG);
   assign reg_field = {{PAD_W{1'b0}}, addr[REG_FIELD_W-1:0]};

   always_comb begin
      legal = 1'b0;
      frame = '0;
      unique case (req_op_e'(op))
         OPC_CMD: begin
            legal            = |code_hit;
            frame.bits       = {wdata, 16'h0000};
            frame.long_frame = 1'b0;
         end
         OPC_RD: begin
            legal            = addr_ok;
            frame.bits       = {RD_BASE | reg_field, 8'h00, 8'h00};
            frame.long_frame = 1'b1;
            frame.is_read    = 1'b1;
         end
         OPC_WR: begin
            legal            = addr_ok;
            frame.bits       = {WR_BASE | reg_field, 8'h00, wdata};
            frame.long_frame = 1'b1;
         end
         default: legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/adc_spi_tick_gen.sv
module adc_spi_tick_gen #(
   parameter int HALF_DIV = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (HALF_DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || !run) begin
            cnt <= '0;
         end else if (cnt == CW'(HALF_DIV - 1)) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = run && (cnt == CW'(HALF_DIV - 1));

      // R7
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick)
         else $error("tick_gap_chk");
   end

endmodule

// File: rtl/adc_spi_shift_engine.sv
module adc_spi_shift_engine
   import adc_spi_seq_pkg::*;
#(
   parameter int HOLD_CYC = 245
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  frame_t            frame,
   input  logic              tick,
   input  logic              miso,
   output logic              run,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rd_data,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);

   localparam int BLW = $clog2(FRAME_W);
   localparam int HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} eng_st_e;

   eng_st_e            st;
   logic [FRAME_W-1:0] txsr;
   logic [BYTE_W-1:0]  rxsr;
   logic [BLW-1:0]     bits_left;
   logic [HCW-1:0]     hold_cnt;
   logic               is_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         txsr      <= '0;
         rxsr      <= '0;
         bits_left <= '0;
         hold_cnt  <= '0;
         is_rd     <= 1'b0;
         done      <= 1'b0;
         rd_data   <= '0;
         sclk      <= 1'b0;
         mosi      <= 1'b0;
         cs_n      <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st        <= ST_SHIFT;
                  cs_n      <= 1'b0;
                  sclk      <= 1'b0;
                  txsr      <= frame.bits;
                  is_rd     <= frame.is_read;
                  bits_left <= frame.long_frame ? BLW'(FRAME_W - 1)
                                                : BLW'(BYTE_W - 1);
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                     mosi <= txsr[FRAME_W-1];
                     txsr <= {txsr[FRAME_W-2:0], 1'b0};
                  end else begin
                     sclk <= 1'b0;
                     rxsr <= {rxsr[BYTE_W-2:0], miso};
                     if (bits_left == '0) begin
                        st       <= ST_HOLD;
                        hold_cnt <= '0;
                     end else begin
                        bits_left <= bits_left - 1'b1;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (hold_cnt == HCW'(HOLD_CYC - 1)) begin
                  st   <= ST_IDLE;
                  cs_n <= 1'b1;
                  mosi <= 1'b0;
                  done <= 1'b1;
                  if (is_rd) begin
                     rd_data <= rxsr;
                  end
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign run  = (st == ST_SHIFT);
   assign busy = (st != ST_IDLE);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done_pulse_chk");

   // R8
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done)
      else $error("cs_release_chk");

   // R7
   sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n)
      else $error("sclk_framed_chk");

   // R7
   mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$rose(sclk) && !$rose(cs_n)) |-> $stable(mosi))
      else $error("mosi_launch_chk");

   // R4
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_data))
      else $error("rdata_hold_chk");

endmodule

// File: rtl/adc_spi_seq.sv
module adc_spi_seq
   import adc_spi_seq_pkg::*;
#(
   parameter int SYS_CLK_HZ        = 125_000_000,
   parameter int CONV_CLK_HZ       = 2_048_000,
   parameter int HALF_DIV          = 31,
   parameter int CS_HOLD_CONV_CLKS = 4,
   parameter int ADDR_W            = 8,
   parameter int REG_FIELD_W       = 5,
   parameter int MAX_REG           = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              busy,
   output logic              done,
   output logic [7:0]        rd_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);

   localparam longint HOLD_NUM = longint'(CS_HOLD_CONV_CLKS) * longint'(SYS_CLK_HZ);
   localparam int     HOLD_CYC = int'((HOLD_NUM + longint'(CONV_CLK_HZ) - 1)
                                      / longint'(CONV_CLK_HZ));

   initial begin
      assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");
      assert (longint'(SYS_CLK_HZ) <= longint'(CONV_CLK_HZ) * 2 * longint'(HALF_DIV))
         else $error("serial clock would exceed the converter clock");
      assert (HOLD_CYC >= 1) else $error("chip-select hold must be at least one cycle");
      assert (REG_FIELD_W <= BYTE_W && ADDR_W >= REG_FIELD_W && ADDR_W <= 16)
         else $error("address widths out of range");
      assert (MAX_REG < (1 << REG_FIELD_W)) else $error("MAX_REG does not fit the address field");
   end

   logic   legal;
   logic   start;
   logic   run;
   logic   tick;
   frame_t frame;

   adc_spi_frame_build #(
      .ADDR_W      (ADDR_W),
      .REG_FIELD_W (REG_FIELD_W),
      .MAX_REG     (MAX_REG)
   ) u_build (
      .op    (req_op),
      .addr  (req_addr),
      .wdata (req_wdata),
      .legal (legal),
      .frame (frame)
   );

   adc_spi_tick_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   assign start = req_valid && !busy && legal;

   adc_spi_shift_engine #(
      .HOLD_CYC (HOLD_CYC)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .frame   (frame),
      .tick    (tick),
      .miso    (miso),
      .run     (run),
      .busy    (busy),
      .done    (done),
      .rd_data (rd_data),
      .sclk    (sclk),
      .mosi    (mosi),
      .cs_n    (cs_n)
   );

   // R3 R6 R10
   accept_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && legal))
      else $error("accept_legal_chk");

endmodule

// File: tb/adc_spi_seq_tb.sv
module adc_spi_seq_tb;

   localparam int HALF = 31;
   // ceil(4 * 125e6 / 2.048e6)
   localparam int HOLD = 245;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [7:0] req_addr = 8'h00;
   logic [7:0] req_wdata = 8'h00;
   logic       busy, done, sclk, mosi, cs_n;
   logic       miso = 1'b0;
   logic [7:0] rd_data;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   adc_spi_seq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .busy      (busy),
      .done      (done),
      .rd_data   (rd_data),
      .sclk      (sclk),
      .mosi      (mosi),
      .miso      (miso),
      .cs_n      (cs_n)
   );

   // ---------------- converter model on the wire ----------------
   logic [23:0] dev_reply = 24'h0;
   logic [23:0] dev_sr = 24'h0;
   always @(negedge cs_n or posedge sclk) begin
      if (sclk) begin
         miso   <= dev_sr[23];
         dev_sr <= {dev_sr[22:0], 1'b0};
      end else begin
         dev_sr <= dev_reply;
      end
   end

   // ---------------- reference rules ----------------
   function automatic bit ref_legal(logic [1:0] op, logic [7:0] a, logic [7:0] d);
      case (op)
         2'b00: return (d == 8'h02 || d == 8'h04 || d == 8'h06 || d == 8'h08 ||
                        d == 8'h0A || d == 8'h10 || d == 8'h11 || d == 8'h12);
         2'b01, 2'b10: return (a <= 8'h19);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [23:0] ref_frame(logic [1:0] op, logic [7:0] a, logic [7:0] d);
      case (op)
         2'b00:   return {16'h0, d};
         2'b01:   return {8'h20 | a, 8'h00, 8'h00};
         default: return {8'h40 | a, 8'h00, d};
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         if (miscompares < 40)
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- cycle model ----------------
   bit          m_act = 1'b0;
   int          m_t = 0;
   int          m_n = 8;
   bit          m_rd = 1'b0;
   bit          m_done = 1'b0;
   logic [7:0]  m_rdata = 8'h00;
   logic [23:0] m_reply = 24'h0;
   logic [23:0] m_frame = 24'h0;
   logic [1:0]  m_op = 2'b00;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 1'b0; m_t = 0; m_done = 1'b0; m_rdata = 8'h00;
      end else if (m_act) begin
         m_done = 1'b0;
         m_t++;
         if (m_t == 2 * m_n * HALF + HOLD) begin
            m_act  = 1'b0;
            m_done = 1'b1;
            if (m_rd) m_rdata = m_reply[7:0];
         end
      end else begin
         m_done = 1'b0;
         if (req_valid && ref_legal(req_op, req_addr, req_wdata)) begin
            m_act   = 1'b1;
            m_t     = 0;
            m_n     = (req_op == 2'b00) ? 8 : 24;
            m_rd    = (req_op == 2'b01);
            m_op    = req_op;
            m_frame = ref_frame(req_op, req_addr, req_wdata);
            m_reply = dev_reply;
         end
      end
   end

   // ---------------- per-cycle comparison and frame capture ----------------
   logic        prev_cs = 1'b1;
   logic        prev_sclk = 1'b0;
   logic [23:0] cap = 24'h0;
   int          cap_n = 0;
   int          since_cs = 0;
   int          since_fall = 0;

   always @(negedge clk) begin
      bit exp_sclk;
      string ftag;
      exp_sclk = m_act && (m_t < 2 * m_n * HALF) && (((m_t / HALF) % 2) == 1);
      chk(cs_n === !m_act, rst_n ? "R8" : "R1", "cs_n", 32'(cs_n), 32'(!m_act));
      chk(sclk === exp_sclk, rst_n ? "R7" : "R1", "sclk", 32'(sclk), 32'(exp_sclk));
      chk(busy === m_act, rst_n ? "R9" : "R1", "busy", 32'(busy), 32'(m_act));
      chk(done === m_done, rst_n ? "R9" : "R1", "done", 32'(done), 32'(m_done));
      chk(rd_data === m_rdata, rst_n ? "R4" : "R1", "rd_data", 32'(rd_data), 32'(m_rdata));
      if (!m_act)
         chk(mosi === 1'b0, "R1", "idle mosi", 32'(mosi), 32'h0);

      if (prev_cs && !cs_n) begin
         cap = 24'h0; cap_n = 0; since_cs = 0;
      end else begin
         since_cs++;
      end
      if (prev_sclk && !sclk) begin
         cap = {cap[22:0], mosi}; cap_n++; since_fall = 0;
      end else begin
         since_fall++;
      end
      // R7 first rising edge placement
      if (!prev_sclk && sclk && cap_n == 0)
         chk(since_cs == HALF, "R7", "cs-to-first-rise cycles", 32'(since_cs), 32'(HALF));
      if (!prev_cs && cs_n) begin
         // R8 hold measured from last falling edge
         chk(since_fall == HOLD, "R8", "cs hold cycles", 32'(since_fall), 32'(HOLD));
         ftag = (m_op == 2'b00) ? "R2" : (m_op == 2'b01) ? "R4" : "R5";
         chk(cap_n == m_n, ftag, "frame bit count", 32'(cap_n), 32'(m_n));
         chk(cap === m_frame, ftag, "frame bits", 32'(cap), 32'(m_frame));
      end
      prev_cs   = cs_n;
      prev_sclk = sclk;
   end

   // ---------------- watchdog ----------------
   always @(negedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=%0d expected<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_req(input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] d, input logic [23:0] reply);
      @(negedge clk);
      dev_reply = reply;
      req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      if (op == 2'b01)
         chk(rd_data === reply[7:0], "R4", "read byte", 32'(rd_data), 32'(reply[7:0]));
      @(negedge clk);
   endtask

   task automatic do_ign(input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] d, input string tag);
      @(negedge clk);
      req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy === 1'b0 && cs_n === 1'b1, tag, "ignored request",
          32'({busy, cs_n}), 32'b01);
   endtask

   initial begin
      logic [7:0] codes [8];
      logic [7:0] held;
      codes = '{8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h10, 8'h11, 8'h12};

      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1", "pins in reset",
          32'({cs_n, sclk, mosi}), 32'b100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && rd_data === 8'h00, "R1", "after reset",
          32'({busy, done, rd_data}), 32'h0);

      // R2 every command code
      foreach (codes[i]) do_req(2'b00, 8'h00, codes[i], 24'h5A5A5A);

      // R3 near-miss codes and reserved opcode
      do_ign(2'b00, 8'h00, 8'h03, "R3");
      do_ign(2'b00, 8'h00, 8'h13, "R3");
      do_ign(2'b00, 8'h00, 8'h00, "R3");
      do_ign(2'b11, 8'h05, 8'h02, "R3");

      // R4 reads, boundary addresses and bit patterns
      do_req(2'b01, 8'h00, 8'h00, 24'h0000A5);
      do_req(2'b01, 8'h19, 8'h00, 24'hFFFF3C);
      do_req(2'b01, 8'h05, 8'h00, 24'h123481);
      do_req(2'b01, 8'h12, 8'h00, 24'h0000FF);
      do_req(2'b01, 8'h0B, 8'h00, 24'hFFFF00);

      // R6 out-of-range addresses
      do_ign(2'b01, 8'h1A, 8'h00, "R6");
      do_ign(2'b10, 8'hFF, 8'h55, "R6");

      // R5 writes leave rd_data alone
      do_req(2'b01, 8'h07, 8'h00, 24'h0000C3);
      held = rd_data;
      do_req(2'b10, 8'h01, 8'h86, 24'hFFFFFF);
      chk(rd_data === held, "R5", "rd_data after write", 32'(rd_data), 32'(held));
      do_req(2'b10, 8'h19, 8'h01, 24'h0);
      do_req(2'b10, 8'h0C, 8'hF0, 24'hABCDEF);
      chk(rd_data === held, "R5", "rd_data after writes", 32'(rd_data), 32'(held));

      // R10 request while busy
      @(negedge clk);
      dev_reply = 24'h000042;
      req_op = 2'b01; req_addr = 8'h03; req_wdata = 8'h00; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (100) @(negedge clk);
      req_op = 2'b10; req_addr = 8'h04; req_wdata = 8'hEE; req_valid = 1'b1;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      chk(rd_data === 8'h42, "R10", "read through busy request", 32'(rd_data), 32'h42);
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && cs_n === 1'b1, "R10", "no queued request",
          32'({busy, cs_n}), 32'b01);

      // R11 back-to-back in the done cycle
      @(negedge clk);
      req_op = 2'b00; req_addr = 8'h00; req_wdata = 8'h08; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      dev_reply = 24'h000099;
      req_op = 2'b01; req_addr = 8'h10; req_wdata = 8'h00; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1 && cs_n === 1'b0, "R11", "accept in done cycle",
          32'({busy, cs_n}), 32'b10);
      while (done !== 1'b1) @(negedge clk);
      chk(rd_data === 8'h99, "R11", "second read byte", 32'(rd_data), 32'h99);
      repeat (5) @(negedge clk);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule